// File: doc/BRIEF.md
# Hybrid-Precision Weight Update Controller

This block applies quantized weight gradients to a weight array whose values are split across two stores. Each weight has a 7-bit signed low field and a coarse high value. The low field keeps one binary cell per bit. The high value is the difference of two increment-only cells. A caller presents one row of raw gradients at a time through a ready/valid handshake. For every weight in that row, the block quantizes the gradient and adds it to the low field with a read-modify-write. Only the bits that change are toggled. When the sum leaves the low range, the field wraps and one program pulse goes to the positive or the negative high cell.

Each update produces a one-cycle event. The event carries the per-bit toggle mask and the per-pair pulse selects, so that the write events on every storage element can be counted. A batch-end pulse advances a counter. When the counter reaches the configured period, the block walks every row and rewrites each high pair as an equivalent pair, which keeps the cells from saturating. New updates stall until this walk is finished. A combinational read port shows the stored low field and both high cells of any row.

Top module: `hybrid_wu_ctrl`

## Requirements
- R1: After reset, `upd_ready` is 1, while `ev_valid` and `refresh_busy` are 0. Every low field and every high cell reads 0.
- R2: The gradient of column c sits in `upd_grad[c*12 +: 12]` as a two's-complement value. Its quantized step is floor(grad / 4), clipped to the range -128..127.
- R3: The new low field is old + step. If that sum is above 63, 128 is subtracted; if it is below -64, 128 is added. The result is read back as two's complement in `rd_low[c*7 +: 7]`.
- R4: `ev_tog[c*7 +: 7]` equals the old low field XOR the new low field, and the store changes exactly those bits. A step of 0 gives a zero mask and no pulse.
- R5: A sum above 63 sets `ev_pos[c]`, and a sum below -64 sets `ev_neg[c]`. `ev_pos[c]` and `ev_neg[c]` are never both set.
- R6: A pulse raises the chosen high cell by exactly 1, and a cell already at 15 stays at 15. High cells change only on a pulse or during a refresh.
- R7: An update is accepted on a clock edge where `upd_valid` and `upd_ready` are both 1. `upd_ready` is 0 in the next cycle. `ev_valid` is 1 for the single cycle after the write edge that follows, and `ev_row` gives the accepted row.
- R8: Each `batch_done` pulse counts one batch while `refresh_period` is nonzero. The pulse that brings the count to `refresh_period` requests a refresh and clears the count. A period of 0 never requests a refresh.
- R9: A refresh keeps `refresh_busy` high for exactly 4 cycles, one per row, and holds `upd_ready` at 0 until it is done. Each pair becomes (p-n, 0) when p >= n and (0, n-p) otherwise. Low fields are left unchanged.
- R10: `rd_low`, `rd_hp` and `rd_hn` show the row selected by `rd_row`, with column c at bit offsets c*7, c*4 and c*4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_valid | input | 1 | Row update request |
| upd_ready | output | 1 | Controller can take an update |
| upd_row | input | 2 | Row to update |
| upd_grad | input | 48 | Raw gradients, 12 bits per column |
| batch_done | input | 1 | One-cycle end-of-batch pulse |
| refresh_period | input | 8 | Batches between refreshes, 0 disables refresh |
| refresh_busy | output | 1 | High-cell refresh walk in progress |
| ev_valid | output | 1 | Update event valid for one cycle |
| ev_row | output | 2 | Row of the event |
| ev_tog | output | 28 | Toggled low bits, 7 per column |
| ev_pos | output | 4 | Positive-cell pulse per column |
| ev_neg | output | 4 | Negative-cell pulse per column |
| rd_row | input | 2 | Read port row select |
| rd_low | output | 28 | Low fields of the selected row |
| rd_hp | output | 16 | Positive cells of the selected row |
| rd_hn | output | 16 | Negative cells of the selected row |

## Verification
The assertions assume that `upd_row` and `rd_row` always name an existing row, and that `refresh_period` is changed only while no refresh is pending. The increment-only check on the high cells also depends on the update path writing the same row that it read. The stimulus draws rows from 0..3 only and changes the period only between batch pulses, after any refresh has finished. The gradients mix zeros, small values, values near the low-field limits and full-range values that drive the clipping, so that single carries and cell saturation both occur under these same conditions.

// File: rtl/hwu_pkg.sv
`timescale 1ns/1ps
// Package: hwu_pkg
// Shared types for the hybrid-precision weight update controller.
// Assumes nothing beyond IEEE 1800-2017 enums.
package hwu_pkg;

    // Sequencer states: idle, single write cycle, refresh row walk.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WRITE   = 2'd1,
        ST_REFRESH = 2'd2
    } wu_state_e;

endpackage

// File: rtl/hwu_lane.sv
`timescale 1ns/1ps
// Module: hwu_lane
// Per-weight datapath. It quantizes one gradient, adds it to the low field
// with wrap-around, derives the toggle mask and the carry pulse, and forms the
// next values of the high cells for an update and for a refresh.
// Assumes GW >= LBITS + 2, so that the clipped step fits the sum width.
module hwu_lane #(
    parameter int LBITS = 7,
    parameter int CW    = 4,
    parameter int GW    = 12,
    parameter int QSH   = 2
) (
    input  logic signed [GW-1:0] grad,
    input  logic [LBITS-1:0]     old_low,
    input  logic [CW-1:0]        hp,
    input  logic [CW-1:0]        hn,
    output logic [LBITS-1:0]     tog,
    output logic                 pos,
    output logic                 neg,
    output logic [CW-1:0]        hp_nxt,
    output logic [CW-1:0]        hn_nxt,
    output logic [CW-1:0]        rf_hp,
    output logic [CW-1:0]        rf_hn
);
    localparam int SW = GW + 1;
    localparam logic signed [SW-1:0] QHI = SW'((2**LBITS) - 1);
    localparam logic signed [SW-1:0] QLO = SW'(-(2**LBITS));
    localparam logic signed [SW-1:0] LHI = SW'((2**(LBITS-1)) - 1);
    localparam logic signed [SW-1:0] LLO = SW'(-(2**(LBITS-1)));
    localparam logic [CW-1:0]        CMAX = '1;

    logic signed [SW-1:0] q_raw;
    logic signed [SW-1:0] q_clip;
    logic signed [SW-1:0] sum;
    logic [LBITS-1:0]     new_low;
    logic signed [CW:0]   net;

    // Quantize the gradient to the low-field step and clip it to one low range.
    always_comb begin
        q_raw  = $signed({grad[GW-1], grad}) >>> QSH;
        q_clip = (q_raw > QHI) ? QHI : ((q_raw < QLO) ? QLO : q_raw);
    end

    // Add the step to the sign-extended low field and detect overflow in either direction.
    always_comb begin
        sum     = q_clip + $signed({{(SW-LBITS){old_low[LBITS-1]}}, old_low});
        new_low = sum[LBITS-1:0];
        tog     = new_low ^ old_low;
        pos     = (sum > LHI);
        neg     = (sum < LLO);
    end

    // Pulse the chosen increment-only cell; a cell at its top level stays there.
    always_comb begin
        hp_nxt = (pos && hp != CMAX) ? hp + 1'b1 : hp;
        hn_nxt = (neg && hn != CMAX) ? hn + 1'b1 : hn;
    end

    // Refresh value: the net difference goes into one cell and the other is cleared.
    always_comb begin
        net   = $signed({1'b0, hp}) - $signed({1'b0, hn});
        rf_hp = net[CW] ? '0 : net[CW-1:0];
        rf_hn = net[CW] ? CW'(-net) : '0;
    end

endmodule

// File: rtl/hwu_store.sv
`timescale 1ns/1ps
// Module: hwu_store
// Register-array model of the two weight stores. The low fields take toggle
// masks (XOR writes). The high cells take whole-value writes. There are two
// combinational read ports: A for the update datapath, B for the external reader.
// Assumes the row indices are below ROWS and that the A row equals the write row.
module hwu_store #(
    parameter int ROWS  = 4,
    parameter int COLS  = 4,
    parameter int LBITS = 7,
    parameter int CW    = 4,
    localparam int RW   = $clog2(ROWS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [RW-1:0]         arow,
    output logic [COLS*LBITS-1:0] a_low,
    output logic [COLS*CW-1:0]    a_hp,
    output logic [COLS*CW-1:0]    a_hn,
    input  logic                  w_tog_en,
    input  logic [COLS*LBITS-1:0] w_tog,
    input  logic                  w_hi_en,
    input  logic [COLS*CW-1:0]    w_hp,
    input  logic [COLS*CW-1:0]    w_hn,
    input  logic [RW-1:0]         brow,
    output logic [COLS*LBITS-1:0] b_low,
    output logic [COLS*CW-1:0]    b_hp,
    output logic [COLS*CW-1:0]    b_hn
);
    logic [LBITS-1:0] low_m [ROWS][COLS];
    logic [CW-1:0]    hp_m  [ROWS][COLS];
    logic [CW-1:0]    hn_m  [ROWS][COLS];

    // Clear on reset, then toggle the flagged low bits and overwrite the high cells of row A.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                for (int c = 0; c < COLS; c++) begin
                    low_m[r][c] <= '0;
                    hp_m[r][c]  <= '0;
                    hn_m[r][c]  <= '0;
                end
            end
        end else begin
            if (w_tog_en) begin
                for (int c = 0; c < COLS; c++)
                    low_m[arow][c] <= low_m[arow][c] ^ w_tog[c*LBITS +: LBITS];
            end
            if (w_hi_en) begin
                for (int c = 0; c < COLS; c++) begin
                    hp_m[arow][c] <= w_hp[c*CW +: CW];
                    hn_m[arow][c] <= w_hn[c*CW +: CW];
                end
            end
        end
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col
        // Combinational read ports for the datapath and for the external reader.
        assign a_low[c*LBITS +: LBITS] = low_m[arow][c];
        assign a_hp[c*CW +: CW]        = hp_m[arow][c];
        assign a_hn[c*CW +: CW]        = hn_m[arow][c];
        assign b_low[c*LBITS +: LBITS] = low_m[brow][c];
        assign b_hp[c*CW +: CW]        = hp_m[brow][c];
        assign b_hn[c*CW +: CW]        = hn_m[brow][c];

        // R6: an update write moves each high cell up by at most one level.
        assert_hi_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (w_tog_en && w_hi_en) |->
                ((w_hp[c*CW +: CW] == a_hp[c*CW +: CW]) ||
                 (w_hp[c*CW +: CW] == a_hp[c*CW +: CW] + 1'b1)) &&
                ((w_hn[c*CW +: CW] == a_hn[c*CW +: CW]) ||
                 (w_hn[c*CW +: CW] == a_hn[c*CW +: CW] + 1'b1)));
    end

endmodule

// File: rtl/hwu_seq.sv
`timescale 1ns/1ps
// Module: hwu_seq
// Control sequencer. It runs the handshake (one write cycle for each accepted
// update), the batch counter, and the refresh walk over all rows.
// Assumes refresh_period changes only while no refresh is pending.
module hwu_seq import hwu_pkg::*; #(
    parameter int ROWS = 4,
    parameter int PW   = 8,
    localparam int RW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_valid,
    input  logic          batch_done,
    input  logic [PW-1:0] refresh_period,
    output logic          upd_ready,
    output logic          accept,
    output logic          write_en,
    output logic          refresh_en,
    output logic [RW-1:0] rf_row
);
    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

    wu_state_e     state;
    logic [PW-1:0] bcnt;
    logic          rf_pend;
    logic          start_rf;
    logic          batch_hit;

    // Decode the handshake and the refresh start from state.
    always_comb begin
        upd_ready  = (state == ST_IDLE) && !rf_pend;
        accept     = upd_valid && upd_ready;
        start_rf   = (state == ST_IDLE) && rf_pend;
        write_en   = (state == ST_WRITE);
        refresh_en = (state == ST_REFRESH);
        batch_hit  = batch_done && (refresh_period != '0) &&
                     (bcnt + 1'b1 >= refresh_period);
    end

    // Count batches and latch a refresh request when the period is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt    <= '0;
            rf_pend <= 1'b0;
        end else begin
            if (start_rf)
                rf_pend <= 1'b0;
            if (batch_done && refresh_period != '0) begin
                if (batch_hit) begin
                    bcnt    <= '0;
                    rf_pend <= 1'b1;
                end else begin
                    bcnt <= bcnt + 1'b1;
                end
            end
        end
    end

    // State transitions: idle to write or refresh, the refresh walk, back to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            rf_row <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_rf) begin
                        state  <= ST_REFRESH;
                        rf_row <= '0;
                    end else if (accept) begin
                        state <= ST_WRITE;
                    end
                end
                ST_WRITE: state <= ST_IDLE;
                ST_REFRESH: begin
                    if (rf_row == LAST_ROW)
                        state <= ST_IDLE;
                    else
                        rf_row <= rf_row + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R7: the cycle after an accept is the write cycle, and no update is taken then.
    assert_stall_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (write_en && !upd_ready));

    // R9: no update is taken during the refresh walk.
    assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_en |-> !upd_ready);

    // R9: the walk continues until the last row has been rewritten.
    assert_walk_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_en && rf_row != LAST_ROW) |=> refresh_en);

    // R8: a walk begins only after a pending request.
    assert_refresh_requested_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(refresh_en) |-> $past(rf_pend));

endmodule

// File: rtl/hybrid_wu_ctrl.sv
`timescale 1ns/1ps
// Module: hybrid_wu_ctrl
// Top of the hybrid-precision weight update controller. It captures a row of
// gradients on the handshake, runs one lane per column against the stores,
// and registers the per-update event (toggle mask and pulse selects).
// Assumes upd_row and rd_row are below ROWS.
module hybrid_wu_ctrl #(
    parameter int ROWS  = 4,
    parameter int COLS  = 4,
    parameter int LBITS = 7,
    parameter int CW    = 4,
    parameter int GW    = 12,
    parameter int QSH   = 2,
    parameter int PW    = 8,
    localparam int RW   = $clog2(ROWS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  upd_valid,
    output logic                  upd_ready,
    input  logic [RW-1:0]         upd_row,
    input  logic [COLS*GW-1:0]    upd_grad,
    input  logic                  batch_done,
    input  logic [PW-1:0]         refresh_period,
    output logic                  refresh_busy,
    output logic                  ev_valid,
    output logic [RW-1:0]         ev_row,
    output logic [COLS*LBITS-1:0] ev_tog,
    output logic [COLS-1:0]       ev_pos,
    output logic [COLS-1:0]       ev_neg,
    input  logic [RW-1:0]         rd_row,
    output logic [COLS*LBITS-1:0] rd_low,
    output logic [COLS*CW-1:0]    rd_hp,
    output logic [COLS*CW-1:0]    rd_hn
);
    logic                  accept;
    logic                  write_en;
    logic                  refresh_en;
    logic [RW-1:0]         rf_row;
    logic [RW-1:0]         op_row;
    logic [COLS*GW-1:0]    op_grad;
    logic [RW-1:0]         act_row;
    logic [COLS*LBITS-1:0] a_low;
    logic [COLS*CW-1:0]    a_hp;
    logic [COLS*CW-1:0]    a_hn;
    logic [COLS*LBITS-1:0] l_tog;
    logic [COLS-1:0]       l_pos;
    logic [COLS-1:0]       l_neg;
    logic [COLS*CW-1:0]    l_hp_nxt;
    logic [COLS*CW-1:0]    l_hn_nxt;
    logic [COLS*CW-1:0]    l_rf_hp;
    logic [COLS*CW-1:0]    l_rf_hn;
    logic [COLS*CW-1:0]    w_hp;
    logic [COLS*CW-1:0]    w_hn;

    hwu_seq #(.ROWS(ROWS), .PW(PW)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .upd_valid      (upd_valid),
        .batch_done     (batch_done),
        .refresh_period (refresh_period),
        .upd_ready      (upd_ready),
        .accept         (accept),
        .write_en       (write_en),
        .refresh_en     (refresh_en),
        .rf_row         (rf_row)
    );

    assign refresh_busy = refresh_en;

    // Capture the accepted row and its gradients for the write cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_row  <= '0;
            op_grad <= '0;
        end else if (accept) begin
            op_row  <= upd_row;
            op_grad <= upd_grad;
        end
    end

    // Select the row the stores work on: the refresh walk row or the captured update row.
    always_comb begin
        act_row = refresh_en ? rf_row : op_row;
        w_hp    = refresh_en ? l_rf_hp : l_hp_nxt;
        w_hn    = refresh_en ? l_rf_hn : l_hn_nxt;
    end

    for (genvar c = 0; c < COLS; c++) begin : g_lane
        hwu_lane #(.LBITS(LBITS), .CW(CW), .GW(GW), .QSH(QSH)) u_lane (
            .grad    (op_grad[c*GW +: GW]),
            .old_low (a_low[c*LBITS +: LBITS]),
            .hp      (a_hp[c*CW +: CW]),
            .hn      (a_hn[c*CW +: CW]),
            .tog     (l_tog[c*LBITS +: LBITS]),
            .pos     (l_pos[c]),
            .neg     (l_neg[c]),
            .hp_nxt  (l_hp_nxt[c*CW +: CW]),
            .hn_nxt  (l_hn_nxt[c*CW +: CW]),
            .rf_hp   (l_rf_hp[c*CW +: CW]),
            .rf_hn   (l_rf_hn[c*CW +: CW])
        );
    end

    hwu_store #(.ROWS(ROWS), .COLS(COLS), .LBITS(LBITS), .CW(CW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .arow     (act_row),
        .a_low    (a_low),
        .a_hp     (a_hp),
        .a_hn     (a_hn),
        .w_tog_en (write_en),
        .w_tog    (l_tog),
        .w_hi_en  (write_en | refresh_en),
        .w_hp     (w_hp),
        .w_hn     (w_hn),
        .brow     (rd_row),
        .b_low    (rd_low),
        .b_hp     (rd_hp),
        .b_hn     (rd_hn)
    );

    // Register the update event for one cycle after the write edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_valid <= 1'b0;
            ev_row   <= '0;
            ev_tog   <= '0;
            ev_pos   <= '0;
            ev_neg   <= '0;
        end else begin
            ev_valid <= write_en;
            if (write_en) begin
                ev_row <= op_row;
                ev_tog <= l_tog;
                ev_pos <= l_pos;
                ev_neg <= l_neg;
            end
        end
    end

    // R5: a weight never pulses both cells of its pair in one update.
    assert_one_side_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> ((ev_pos & ev_neg) == '0));

    // R7: an event appears only one cycle after a write cycle.
    assert_event_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> $past(write_en));

endmodule

// File: tb/hybrid_wu_ctrl_tb.sv
`timescale 1ns/1ps
// Bench for hybrid_wu_ctrl: directed corner cases plus seeded random updates,
// checked against a behavioural model of the weight stores.
module hybrid_wu_ctrl_tb;
    localparam int ROWS = 4, COLS = 4, LB = 7, CW = 4, GW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic upd_valid = 1'b0;
    logic upd_ready;
    logic [1:0] upd_row = '0;
    logic [COLS*GW-1:0] upd_grad = '0;
    logic batch_done = 1'b0;
    logic [7:0] refresh_period = '0;
    logic refresh_busy;
    logic ev_valid;
    logic [1:0] ev_row;
    logic [COLS*LB-1:0] ev_tog;
    logic [COLS-1:0] ev_pos, ev_neg;
    logic [1:0] rd_row = '0;
    logic [COLS*LB-1:0] rd_low;
    logic [COLS*CW-1:0] rd_hp, rd_hn;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int mlow [ROWS][COLS];
    int mhp  [ROWS][COLS];
    int mhn  [ROWS][COLS];

    always #2.5 clk = ~clk;

    hybrid_wu_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_ready(upd_ready),
        .upd_row(upd_row), .upd_grad(upd_grad), .batch_done(batch_done),
        .refresh_period(refresh_period), .refresh_busy(refresh_busy),
        .ev_valid(ev_valid), .ev_row(ev_row), .ev_tog(ev_tog), .ev_pos(ev_pos),
        .ev_neg(ev_neg), .rd_row(rd_row), .rd_low(rd_low), .rd_hp(rd_hp), .rd_hn(rd_hn)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // R2: quantized step, floor(g/4) clipped to -128..127.
    function automatic int qstep(input int g);
        int s;
        s = g >>> 2;
        if (s > 127) s = 127;
        if (s < -128) s = -128;
        return s;
    endfunction

    // R10: compare one row read through the read port with the model.
    task automatic check_row(input int r, input string req);
        logic [COLS*LB-1:0] el;
        logic [COLS*CW-1:0] ep, en;
        for (int c = 0; c < COLS; c++) begin
            el[c*LB +: LB] = LB'(mlow[r][c]);
            ep[c*CW +: CW] = CW'(mhp[r][c]);
            en[c*CW +: CW] = CW'(mhn[r][c]);
        end
        rd_row = 2'(r);
        #1;
        chk(rd_low == el, req, "low fields", longint'(rd_low), longint'(el));
        chk(rd_hp == ep, req, "positive cells", longint'(rd_hp), longint'(ep));
        chk(rd_hn == en, req, "negative cells", longint'(rd_hn), longint'(en));
    endtask

    task automatic check_all(input string req);
        for (int r = 0; r < ROWS; r++) check_row(r, req);
    endtask

    // R3 R4 R5 R6 R7: one row update with model prediction and event check.
    task automatic do_update(input int row, input int g [COLS]);
        logic [COLS*LB-1:0] etog;
        logic [COLS-1:0] ep, en;
        int s, nl;
        for (int c = 0; c < COLS; c++) begin
            s = mlow[row][c] + qstep(g[c]);
            nl = s;
            ep[c] = (s > 63);
            en[c] = (s < -64);
            if (s > 63) nl = s - 128;
            if (s < -64) nl = s + 128;
            etog[c*LB +: LB] = LB'(mlow[row][c]) ^ LB'(nl);
            mlow[row][c] = nl;
            if (ep[c] && mhp[row][c] < 15) mhp[row][c]++;
            if (en[c] && mhn[row][c] < 15) mhn[row][c]++;
        end
        @(negedge clk);
        upd_valid = 1'b1;
        upd_row = 2'(row);
        for (int c = 0; c < COLS; c++) upd_grad[c*GW +: GW] = GW'(g[c]);
        while (!upd_ready) @(negedge clk);
        @(negedge clk);
        upd_valid = 1'b0;
        chk(!upd_ready, "R7", "ready in write cycle", longint'(upd_ready), 0);
        @(negedge clk);
        chk(ev_valid && ev_row == 2'(row), "R7", "event valid/row",
            longint'({ev_valid, ev_row}), longint'({1'b1, 2'(row)}));
        chk(ev_tog == etog, "R4", "toggle mask", longint'(ev_tog), longint'(etog));
        chk(ev_pos == ep, "R5", "positive pulses", longint'(ev_pos), longint'(ep));
        chk(ev_neg == en, "R5", "negative pulses", longint'(ev_neg), longint'(en));
        check_row(row, "R3");
    endtask

    // R8 R9: one batch pulse; a refresh is expected or not.
    task automatic batch_pulse(input bit expect_rf);
        int busy_n;
        @(negedge clk);
        batch_done = 1'b1;
        @(negedge clk);
        batch_done = 1'b0;
        if (!expect_rf) begin
            chk(upd_ready && !refresh_busy, "R8", "no refresh before period",
                longint'({upd_ready, refresh_busy}), 2);
        end else begin
            busy_n = 0;
            for (int k = 0; k < 30; k++) begin
                if (refresh_busy) begin
                    busy_n++;
                    if (upd_ready) chk(0, "R9", "ready during refresh", 1, 0);
                end
                if (upd_ready) break;
                @(negedge clk);
            end
            chk(busy_n == ROWS, "R9", "refresh busy cycles", busy_n, ROWS);
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS; c++) begin
                    int d;
                    d = mhp[r][c] - mhn[r][c];
                    mhp[r][c] = (d >= 0) ? d : 0;
                    mhn[r][c] = (d < 0) ? -d : 0;
                end
            check_all("R9");
        end
    endtask

    function automatic int rand_grad();
        int k;
        k = int'($urandom % 4);
        case (k)
            0: return 0;
            1: return int'($urandom % 81) - 40;
            2: return int'($urandom % 1201) - 600;
            default: return int'($urandom % 4096) - 2048;
        endcase
    endfunction

    initial begin
        int g [COLS];
        void'($urandom(32'd20241));
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                mlow[r][c] = 0; mhp[r][c] = 0; mhn[r][c] = 0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(upd_ready && !ev_valid && !refresh_busy, "R1", "reset outputs",
            longint'({upd_ready, ev_valid, refresh_busy}), 4);
        check_all("R1");

        // Directed: bring col0 to 63, col1 to -64, col2 zero step, col3 clipped step.
        g = '{252, -256, 0, 2047};
        do_update(1, g);
        // col0 +1 -> wrap with positive carry; col1 -1 -> wrap with negative carry; col2 zero (R4).
        g = '{4, -4, 3, -2048};
        do_update(1, g);
        // R2: negative floor (-1 gives step -1), small values.
        g = '{-1, 1, -5, 7};
        do_update(2, g);

        // R6: drive positive-cell saturation on row 0.
        for (int i = 0; i < 20; i++) begin
            g = '{508, 508, -512, 0};
            do_update(0, g);
        end

        // Seeded random updates.
        for (int i = 0; i < 60; i++) begin
            for (int c = 0; c < COLS; c++) g[c] = rand_grad();
            do_update(int'($urandom % ROWS), g);
        end

        // R8: a period of 0 never refreshes.
        refresh_period = 8'd0;
        repeat (3) batch_pulse(1'b0);
        check_all("R8");
        // Period 3: the third pulse triggers, and the count then restarts.
        refresh_period = 8'd3;
        batch_pulse(1'b0);
        batch_pulse(1'b0);
        batch_pulse(1'b1);
        for (int i = 0; i < 10; i++) begin
            for (int c = 0; c < COLS; c++) g[c] = rand_grad();
            do_update(int'($urandom % ROWS), g);
        end
        batch_pulse(1'b0);
        batch_pulse(1'b0);
        batch_pulse(1'b1);
        check_all("R10");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #900000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule